// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a compact processor whose arithmetic and logic instructions carry no operand fields. Every two-input operation takes its inputs from the top of an internal operand stack and leaves its result there. Only two instructions hold an address: a fetch-to-stack instruction that copies a data-memory word onto the stack, and a stack-to-memory instruction that writes the top word out and removes it. Three reordering instructions (duplicate, exchange, discard) let a program reuse a value without reloading it.

The core reads bytes from an external program memory and drives a simple data-memory port. Both memories answer combinationally within the same cycle. A controlling state machine steps through four states. `ST_FETCH` latches the opcode. `ST_ADDR` latches the address byte and is used only by the two memory instructions. `ST_EXEC` performs the operation. `ST_HALT` is terminal. The transitions are: fetch-to-address when the opcode is a memory instruction, fetch-to-execute otherwise, address-to-execute always, execute-to-halt on the stop opcode, execute-to-fetch otherwise, and halt-to-halt.

Opcodes, one byte each: 0x00 no-op, 0x01 add, 0x02 subtract, 0x03 multiply, 0x04 AND, 0x05 OR, 0x06 XOR, 0x08 duplicate, 0x09 swap, 0x0A drop, 0x10 load (followed by an address byte), 0x11 store (followed by an address byte), 0xFF halt.

Top module: `opstack_cpu`

## Requirements
- R1: While reset is asserted, and after it is released, the program address is 0, the stack is empty, `done` and `stk_err` are low and `dmem_we` is low.
- R2: A one-byte instruction takes two cycles (fetch, execute) and a two-byte instruction takes three (fetch, address, execute). `imem_addr` advances by one at the end of each fetch and address cycle and is otherwise held.
- R3: The binary opcodes 0x01 to 0x06 take the second-from-top entry as left operand and the top entry as right operand. They pop both and push the 8-bit result. Subtract gives left minus right modulo 256, and multiply keeps the low 8 bits of the product.
- R4: Load (0x10, addr) pushes the data-memory word at addr. Store (0x11, addr) drives `dmem_we` high for exactly its execute cycle, with `dmem_addr` = addr and `dmem_wdata` = top entry, and then pops the stack.
- R5: Duplicate (0x08) pushes a copy of the top entry. Swap (0x09) exchanges the top two entries. Drop (0x0A) removes the top entry.
- R6: An instruction that would push onto a full stack (16 entries), such as load or duplicate, sets `stk_err` and leaves the stack contents and depth unchanged.
- R7: An instruction that needs more entries than the stack holds sets `stk_err` and leaves the stack unchanged. A store with an empty stack performs no memory write.
- R8: `stk_err` stays high once set, through any later instructions, until reset.
- R9: After halt (0xFF) executes, `done` is high from the next cycle on, `imem_addr` stays fixed at the byte after the halt and no further write takes place.
- R10: Any opcode byte not listed above behaves as a no-op: two cycles, with no change to the stack or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | PAW | Program memory byte address (program counter) |
| imem_data | input | 8 | Program memory byte at `imem_addr` |
| dmem_addr | output | DAW | Data memory address from the last address byte |
| dmem_wdata | output | W | Data memory write word (current stack top) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | W | Data memory word at `dmem_addr` |
| done | output | 1 | High once a halt has executed |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The hardest case to reach from the ports is an overflow followed by proof that the stack really kept its contents. The stack can only be observed by storing from it, so the bench fills all sixteen entries with loads of one value. It then tries a seventeenth load of a different value and a duplicate, and stores the top. The stored word must be the original value, not the rejected one. Underflow is driven the same way: a binary operation, a swap and a drop are each issued with too few entries, and a store on an empty stack targets a location preloaded with a marker, which must survive. A behavioural model built on a queue predicts every cycle's program address, write strobe, address, data and flags, and the bench compares them clock by clock.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

    localparam int unsigned OPW = 8;

    localparam logic [OPW-1:0] OP_NOP   = 8'h00;
    localparam logic [OPW-1:0] OP_ADD   = 8'h01;
    localparam logic [OPW-1:0] OP_SUB   = 8'h02;
    localparam logic [OPW-1:0] OP_MUL   = 8'h03;
    localparam logic [OPW-1:0] OP_AND   = 8'h04;
    localparam logic [OPW-1:0] OP_OR    = 8'h05;
    localparam logic [OPW-1:0] OP_XOR   = 8'h06;
    localparam logic [OPW-1:0] OP_DUP   = 8'h08;
    localparam logic [OPW-1:0] OP_SWAP  = 8'h09;
    localparam logic [OPW-1:0] OP_DROP  = 8'h0A;
    localparam logic [OPW-1:0] OP_LOAD  = 8'h10;
    localparam logic [OPW-1:0] OP_STORE = 8'h11;
    localparam logic [OPW-1:0] OP_HALT  = 8'hFF;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_ADDR,
        ST_EXEC,
        ST_HALT
    } cpu_state_e;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_PUSH,
        SK_POP,
        SK_BIN,
        SK_DUP,
        SK_SWAP
    } stack_cmd_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_AND,
        ALU_OR,
        ALU_XOR
    } alu_fn_e;

endpackage

// File: rtl/opstack_alu.sv
module opstack_alu
    import opstack_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   res
);

    // Left operand is the entry below the top, right operand is the top.
    always_comb begin
        unique case (fn)
            ALU_ADD: res = lhs + rhs;
            ALU_SUB: res = lhs - rhs;
            ALU_MUL: res = lhs * rhs;   // context width W keeps the low half
            ALU_AND: res = lhs & rhs;
            ALU_OR:  res = lhs | rhs;
            ALU_XOR: res = lhs ^ rhs;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/opstack_stack.sv
module opstack_stack
    import opstack_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  stack_cmd_e   cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] tos,
    output logic [W-1:0] nos,
    output logic         fault
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] TWO  = CW'(2);

    logic [DEPTH-1:0][W-1:0] ent;
    logic [CW-1:0]           fill;
    logic [IW-1:0]           idx_top;
    logic [IW-1:0]           idx_nos;
    logic [IW-1:0]           idx_new;
    logic                    apply;

    logic                    wa_en;
    logic [IW-1:0]           wa_idx;
    logic [W-1:0]            wa_dat;
    logic                    wb_en;
    logic [IW-1:0]           wb_idx;
    logic [W-1:0]            wb_dat;

    assign idx_top = IW'(fill - ONE);
    assign idx_nos = IW'(fill - TWO);
    assign idx_new = IW'(fill);

    assign tos = (fill != '0) ? ent[idx_top] : '0;
    assign nos = (fill >= TWO) ? ent[idx_nos] : '0;

    // Legality of the requested command against the current depth
    always_comb begin
        unique case (cmd)
            SK_PUSH: fault = (fill == FULL);
            SK_DUP:  fault = (fill == '0) || (fill == FULL);
            SK_POP:  fault = (fill == '0);
            SK_BIN:  fault = (fill < TWO);
            SK_SWAP: fault = (fill < TWO);
            default: fault = 1'b0;
        endcase
    end

    assign apply = en && !fault;

    // Two write ports: port A serves every command, port B only the swap
    always_comb begin
        wa_en  = 1'b0;
        wa_idx = idx_new;
        wa_dat = wdata;
        wb_en  = 1'b0;
        wb_idx = idx_nos;
        wb_dat = tos;
        if (apply) begin
            unique case (cmd)
                SK_PUSH: begin
                    wa_en = 1'b1;
                end
                SK_DUP: begin
                    wa_en  = 1'b1;
                    wa_dat = tos;
                end
                SK_BIN: begin
                    wa_en  = 1'b1;
                    wa_idx = idx_nos;
                end
                SK_SWAP: begin
                    wa_en  = 1'b1;
                    wa_idx = idx_top;
                    wa_dat = nos;
                    wb_en  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wa_en && (wa_idx == IW'(g))) begin
                q <= wa_dat;
            end else if (wb_en && (wb_idx == IW'(g))) begin
                q <= wb_dat;
            end
        end
        assign ent[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (apply) begin
            unique case (cmd)
                SK_PUSH, SK_DUP: fill <= fill + ONE;
                SK_POP,  SK_BIN: fill <= fill - ONE;
                default:         fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
    import opstack_pkg::*;
#(
    parameter int W   = 8,
    parameter int PAW = 8,
    parameter int DAW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPW-1:0]   imem_data,
    input  logic [W-1:0]     dmem_rdata,
    input  logic [W-1:0]     alu_res,
    input  logic             sk_fault,
    output logic [PAW-1:0]   pc_o,
    output logic [DAW-1:0]   ar_o,
    output logic             mem_we,
    output logic             sk_en,
    output stack_cmd_e       sk_cmd,
    output logic [W-1:0]     sk_wdata,
    output alu_fn_e          alu_fn,
    output logic             halted,
    output logic             err_o
);

    cpu_state_e      state;
    cpu_state_e      nxt;
    logic [PAW-1:0]  pc;
    logic [OPW-1:0]  ir;
    logic [DAW-1:0]  ar;
    logic            err;
    logic            fetch_mem_op;

    assign fetch_mem_op = (imem_data == OP_LOAD) || (imem_data == OP_STORE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decision
    always_comb begin
        unique case (state)
            ST_FETCH: nxt = fetch_mem_op ? ST_ADDR : ST_EXEC;
            ST_ADDR:  nxt = ST_EXEC;
            ST_EXEC:  nxt = (ir == OP_HALT) ? ST_HALT : ST_FETCH;
            ST_HALT:  nxt = ST_HALT;
            default:  nxt = ST_FETCH;
        endcase
    end

    // Program counter, instruction and address latches, sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            ir  <= OP_NOP;
            ar  <= '0;
            err <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir <= imem_data;
                    pc <= pc + 1'b1;
                end
                ST_ADDR: begin
                    ar <= imem_data[DAW-1:0];
                    pc <= pc + 1'b1;
                end
                ST_EXEC: begin
                    if (sk_fault) begin
                        err <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Decode outputs for the execute state
    always_comb begin
        sk_en    = (state == ST_EXEC);
        sk_cmd   = SK_NONE;
        sk_wdata = alu_res;
        alu_fn   = ALU_ADD;
        if (state == ST_EXEC) begin
            unique case (ir)
                OP_ADD:   begin sk_cmd = SK_BIN; alu_fn = ALU_ADD; end
                OP_SUB:   begin sk_cmd = SK_BIN; alu_fn = ALU_SUB; end
                OP_MUL:   begin sk_cmd = SK_BIN; alu_fn = ALU_MUL; end
                OP_AND:   begin sk_cmd = SK_BIN; alu_fn = ALU_AND; end
                OP_OR:    begin sk_cmd = SK_BIN; alu_fn = ALU_OR;  end
                OP_XOR:   begin sk_cmd = SK_BIN; alu_fn = ALU_XOR; end
                OP_DUP:   sk_cmd = SK_DUP;
                OP_SWAP:  sk_cmd = SK_SWAP;
                OP_DROP:  sk_cmd = SK_POP;
                OP_LOAD:  begin sk_cmd = SK_PUSH; sk_wdata = dmem_rdata; end
                OP_STORE: sk_cmd = SK_POP;
                default:  sk_cmd = SK_NONE;
            endcase
        end
    end

    assign mem_we = (state == ST_EXEC) && (ir == OP_STORE) && !sk_fault;
    assign halted = (state == ST_HALT);
    assign pc_o   = pc;
    assign ar_o   = ar;
    assign err_o  = err;

endmodule

// File: rtl/opstack_cpu.sv
module opstack_cpu
    import opstack_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int PAW   = 8,
    parameter int DAW   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PAW-1:0]   imem_addr,
    input  logic [7:0]       imem_data,
    output logic [DAW-1:0]   dmem_addr,
    output logic [W-1:0]     dmem_wdata,
    output logic             dmem_we,
    input  logic [W-1:0]     dmem_rdata,
    output logic             done,
    output logic             stk_err
);

    logic        sk_en;
    logic        sk_fault;
    stack_cmd_e  sk_cmd;
    logic [W-1:0] sk_wdata;
    logic [W-1:0] tos;
    logic [W-1:0] nos;
    alu_fn_e     alu_fn;
    logic [W-1:0] alu_res;

    opstack_ctrl #(
        .W   (W),
        .PAW (PAW),
        .DAW (DAW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_data  (imem_data),
        .dmem_rdata (dmem_rdata),
        .alu_res    (alu_res),
        .sk_fault   (sk_fault),
        .pc_o       (imem_addr),
        .ar_o       (dmem_addr),
        .mem_we     (dmem_we),
        .sk_en      (sk_en),
        .sk_cmd     (sk_cmd),
        .sk_wdata   (sk_wdata),
        .alu_fn     (alu_fn),
        .halted     (done),
        .err_o      (stk_err)
    );

    opstack_stack #(
        .W     (W),
        .DEPTH (DEPTH)
    ) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sk_en),
        .cmd   (sk_cmd),
        .wdata (sk_wdata),
        .tos   (tos),
        .nos   (nos),
        .fault (sk_fault)
    );

    opstack_alu #(
        .W (W)
    ) u_alu (
        .fn  (alu_fn),
        .lhs (nos),
        .rhs (tos),
        .res (alu_res)
    );

    assign dmem_wdata = tos;

endmodule

// File: rtl/opstack_chk.sv
module opstack_chk #(
    parameter int PAW = 8,
    parameter int W   = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [PAW-1:0] imem_addr,
    input logic           dmem_we,
    input logic [W-1:0]   dmem_wdata,
    input logic           done,
    input logic           stk_err,
    input logic           sk_en,
    input logic           sk_fault
);

    // R2: the program address either holds or moves forward by one
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (imem_addr == $past(imem_addr)) ||
                  (imem_addr == $past(imem_addr) + PAW'(1)));

    // R4: a store strobe never lasts longer than one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

    // R6 / R7: a rejected stack command leaves the top entry untouched
    p_fault_keeps_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_en && sk_fault) |=> $stable(dmem_wdata));

    // R7: the error flag only rises after a rejected command
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_err) |-> $past(sk_en && sk_fault));

    // R8: the error flag never falls outside reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    // R9: the halted state is final and frozen
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && $stable(imem_addr));

    // R9: no memory write once halted
    p_halt_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dmem_we);

endmodule

bind opstack_cpu opstack_chk #(
    .PAW (PAW),
    .W   (W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .done       (done),
    .stk_err    (stk_err),
    .sk_en      (sk_en),
    .sk_fault   (sk_fault)
);

// File: tb/sim_opstack_cpu.sv
`timescale 1ns/1ps
module sim_opstack_cpu;

    localparam int LIM = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] imem_addr;
    logic [7:0] imem_data;
    logic [7:0] dmem_addr;
    logic [7:0] dmem_wdata;
    logic       dmem_we;
    logic [7:0] dmem_rdata;
    logic       done;
    logic       stk_err;

    logic [7:0] pm [256];
    logic [7:0] dm [256];

    int n_chk  = 0;
    int n_fail = 0;
    int wp     = 0;

    typedef struct {
        int ia;
        bit we;
        int da;
        int wd;
        bit dn;
        bit er;
    } cyc_t;

    cyc_t exp_q[$];

    always #2.5 clk = ~clk;

    assign imem_data  = pm[imem_addr];
    assign dmem_rdata = dm[dmem_addr];

    opstack_cpu u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .done       (done),
        .stk_err    (stk_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            pm[i] = 8'hFF;
            dm[i] = 8'h00;
        end
        wp = 0;
    endtask

    task automatic put(input logic [7:0] b);
        pm[wp] = b;
        wp++;
    endtask

    task automatic add_cyc(input int ia, input bit we, input int da, input int wd,
                           input bit dn, input bit er);
        cyc_t c;
        c.ia = ia & 255; c.we = we; c.da = da; c.wd = wd; c.dn = dn; c.er = er;
        exp_q.push_back(c);
    endtask

    function automatic int alu_ref(input int op, input int l, input int r);
        case (op)
            1: return (l + r) & 255;
            2: return (l - r) & 255;
            3: return (l * r) & 255;
            4: return l & r;
            5: return l | r;
            default: return l ^ r;
        endcase
    endfunction

    // Behavioural model: instruction-level interpreter emitting per-cycle expectations
    task automatic build_model();
        int stk[$];
        int mdm[256];
        int pc = 0;
        bit er = 1'b0;
        exp_q.delete();
        for (int i = 0; i < 256; i++) mdm[i] = dm[i];
        for (int n = 0; n < 400; n++) begin
            int op = pm[pc];
            if (op == 8'h10 || op == 8'h11) begin
                int a = pm[(pc + 1) & 255];
                add_cyc(pc, 0, 0, 0, 0, er);
                add_cyc(pc + 1, 0, 0, 0, 0, er);
                if (op == 8'h10) begin
                    add_cyc(pc + 2, 0, 0, 0, 0, er);
                    if (stk.size() < LIM) stk.push_back(mdm[a]);
                    else er = 1'b1;
                end else begin
                    if (stk.size() > 0) begin
                        add_cyc(pc + 2, 1, a, stk[$], 0, er);
                        mdm[a] = stk.pop_back();
                    end else begin
                        add_cyc(pc + 2, 0, 0, 0, 0, er);
                        er = 1'b1;
                    end
                end
                pc = (pc + 2) & 255;
            end else begin
                add_cyc(pc, 0, 0, 0, 0, er);
                add_cyc(pc + 1, 0, 0, 0, 0, er);
                if (op == 8'hFF) begin
                    for (int k = 0; k < 20; k++) add_cyc(pc + 1, 0, 0, 0, 1, er);
                    return;
                end
                if (op >= 1 && op <= 6) begin
                    if (stk.size() < 2) er = 1'b1;
                    else begin
                        int r = stk.pop_back();
                        int l = stk.pop_back();
                        stk.push_back(alu_ref(op, l, r));
                    end
                end else if (op == 8'h08) begin
                    if (stk.size() == 0 || stk.size() == LIM) er = 1'b1;
                    else stk.push_back(stk[$]);
                end else if (op == 8'h09) begin
                    if (stk.size() < 2) er = 1'b1;
                    else begin
                        int r = stk.pop_back();
                        int l = stk.pop_back();
                        stk.push_back(r);
                        stk.push_back(l);
                    end
                end else if (op == 8'h0A) begin
                    if (stk.size() == 0) er = 1'b1;
                    else void'(stk.pop_back());
                end
                pc = (pc + 1) & 255;
            end
        end
    endtask

    task automatic run_prog(input string tag);
        build_model();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(imem_addr == 0, "R1", "reset imem_addr", imem_addr, 0);
        check(done == 0, "R1", "reset done", done, 0);
        check(stk_err == 0, "R1", "reset stk_err", stk_err, 0);
        check(dmem_we == 0, "R1", "reset dmem_we", dmem_we, 0);
        rst_n = 1'b1;
        foreach (exp_q[i]) begin
            if (i > 0) @(negedge clk);
            check(imem_addr == exp_q[i].ia[7:0], tag, "imem_addr", imem_addr, exp_q[i].ia);
            check(done == exp_q[i].dn, tag, "done", done, exp_q[i].dn);
            check(stk_err == exp_q[i].er, tag, "stk_err", stk_err, exp_q[i].er);
            check(dmem_we == exp_q[i].we, tag, "dmem_we", dmem_we, exp_q[i].we);
            if (exp_q[i].we) begin
                check(dmem_addr == exp_q[i].da[7:0], tag, "dmem_addr", dmem_addr, exp_q[i].da);
                check(dmem_wdata == exp_q[i].wd[7:0], tag, "dmem_wdata", dmem_wdata, exp_q[i].wd);
            end
            if (dmem_we) dm[dmem_addr] = dmem_wdata;
        end
    endtask

    task automatic init_data();
        dm[0] = 8'd7;   dm[1] = 8'd3;
        dm[2] = 8'd20;  dm[3] = 8'd13;
        dm[4] = 8'hF0;  dm[5] = 8'h3C;
        dm[6] = 8'd200; dm[7] = 8'd100;
    endtask

    task automatic ld(input logic [7:0] a);
        put(8'h10); put(a);
    endtask

    task automatic st(input logic [7:0] a);
        put(8'h11); put(a);
    endtask

    initial begin
        // Program A: operand order, truncation, each binary op, load and store
        clear_mem(); init_data();
        ld(0); ld(1); put(8'h02); st(8'h20);
        ld(1); ld(0); put(8'h02); st(8'h21);
        ld(2); ld(3); put(8'h03); st(8'h22);
        ld(6); ld(7); put(8'h01); st(8'h23);
        ld(4); ld(5); put(8'h04); st(8'h24);
        ld(4); ld(5); put(8'h05); st(8'h25);
        ld(4); ld(5); put(8'h06); st(8'h26);
        put(8'hFF);
        run_prog("R2,R3,R4");
        check(dm[8'h20] == 8'd4,   "R3", "7-3",      dm[8'h20], 4);
        check(dm[8'h21] == 8'hFC,  "R3", "3-7",      dm[8'h21], 8'hFC);
        check(dm[8'h22] == 8'd4,   "R3", "20*13",    dm[8'h22], 4);
        check(dm[8'h23] == 8'd44,  "R3", "200+100",  dm[8'h23], 44);
        check(dm[8'h24] == 8'h30,  "R3", "AND",      dm[8'h24], 8'h30);
        check(dm[8'h25] == 8'hFC,  "R3", "OR",       dm[8'h25], 8'hFC);
        check(dm[8'h26] == 8'hCC,  "R4", "XOR store",dm[8'h26], 8'hCC);

        // Program B: reordering and undefined opcodes
        clear_mem(); init_data();
        ld(0); ld(1); put(8'h09); st(8'h30); st(8'h31);
        ld(2); put(8'h08); put(8'h01); st(8'h32);
        ld(0); ld(1); put(8'h0A); st(8'h33);
        ld(2); put(8'h07); put(8'h55); put(8'h00); st(8'h34);
        put(8'hFF);
        run_prog("R5,R10");
        check(dm[8'h30] == 8'd7,  "R5",  "swap top",  dm[8'h30], 7);
        check(dm[8'h31] == 8'd3,  "R5",  "swap next", dm[8'h31], 3);
        check(dm[8'h32] == 8'd40, "R5",  "dup add",   dm[8'h32], 40);
        check(dm[8'h33] == 8'd7,  "R5",  "drop",      dm[8'h33], 7);
        check(dm[8'h34] == 8'd20, "R10", "undefined opcodes", dm[8'h34], 20);
        check(stk_err == 0, "R10", "no error from undefined", stk_err, 0);

        // Program C: overflow on a full stack
        clear_mem(); init_data();
        for (int k = 0; k < 16; k++) ld(0);
        ld(1); put(8'h08); st(8'h40); put(8'h00);
        put(8'hFF);
        run_prog("R6,R8");
        check(dm[8'h40] == 8'd7, "R6", "top after overflow", dm[8'h40], 7);
        check(stk_err == 1, "R8", "sticky after overflow", stk_err, 1);

        // Program D: underflow cases
        clear_mem(); init_data();
        dm[8'h50] = 8'hAA;
        put(8'h01); st(8'h50); ld(0); put(8'h02); st(8'h51);
        put(8'h09); put(8'h0A);
        put(8'hFF);
        run_prog("R7,R8");
        check(dm[8'h50] == 8'hAA, "R7", "store on empty", dm[8'h50], 8'hAA);
        check(dm[8'h51] == 8'd7,  "R7", "sub underflow keeps", dm[8'h51], 7);
        check(stk_err == 1, "R8", "sticky after underflow", stk_err, 1);

        // Program E: halt first, later bytes must never run
        clear_mem(); init_data();
        put(8'hFF); ld(0); st(8'h60);
        run_prog("R9");
        check(done == 1, "R9", "done held", done, 1);
        check(imem_addr == 8'd1, "R9", "address frozen", imem_addr, 1);
        check(dm[8'h60] == 8'd0, "R9", "no write after halt", dm[8'h60], 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule